// File: doc/BRIEF.md
# Bridge Residence-Time Correction Updater

This block sits in the datapath of a two-port bridge that acts as a transparent clock for a precision time protocol. Each time an event message enters the bridge, the ingress timestamping logic sends a strobe carrying the message type, the sequence number and the local time of arrival. When the same message is about to leave, the egress side sends a strobe with the type, the sequence number, the local departure time and the correction value read from the frame. The block returns the corrected value to the egress frame rewriter. That value is the incoming correction plus the time the message spent inside the bridge. The origin timestamp in the frame is never modified, so only the correction field accumulates. The far endpoint can then subtract the bridge delays it receives in the response message.

Only Sync (type code 0) and Delay_Req (type code 1) are timed. Arrival times wait in a small lookup table keyed by kind and sequence number until the matching departure arrives. Any other message type passes through unchanged. If a departure has no stored arrival, the correction also passes unchanged and a miss flag is raised. The correction is a 64-bit signed value in nanoseconds scaled by 2^16, so the residence time is shifted left by 16 bits before it is added.

Top module: `tc_corr_updater`

## Requirements
- R1: While reset is high and on the first cycle after it, out_valid, out_miss and out_adjusted are low. The table starts empty, so an event departure right after reset is reported as a miss.
- R2: A Sync departure (type 0) that matches a stored Sync arrival with the same sequence number gives out_corr = corr_in + (((egr_ts - ing_ts) mod 2^TS_W) << 16), computed modulo 2^64, with out_adjusted high.
- R3: A Delay_Req departure (type 1) that matches a stored Delay_Req arrival is updated by the same formula, with out_adjusted high.
- R4: Any message type other than 0 and 1 is not stored at arrival. At departure it produces out_corr equal to corr_in with both flags low. A non-event arrival never displaces a stored entry.
- R5: The table key includes the kind. A Sync and a Delay_Req with the same sequence number are held and matched independently.
- R6: An event departure with no matching stored arrival gives out_corr equal to corr_in, out_miss high and out_adjusted low.
- R7: A matched entry is consumed. A second departure with the same kind and sequence number is a miss.
- R8: The table holds DEPTH arrivals, written into slots in cyclic arrival order. Arrival number DEPTH+1 overwrites the slot of the oldest write, which then misses.
- R9: The residence time is taken modulo 2^TS_W, so a departure time that has wrapped past zero still gives the correct positive residence.
- R10: Each departure strobe produces exactly one out_valid pulse of one cycle, two clock edges after the strobe is sampled. out_miss and out_adjusted are never both high, and either one is high only together with out_valid.
- R11: When an arrival and a departure with the same key are strobed in the same cycle, the departure misses and the arrival is stored for a later departure.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ing_valid | input | 1 | Arrival timestamp strobe |
| ing_type | input | 4 | Message type of the arriving frame |
| ing_seq | input | SEQ_W | Sequence number of the arriving frame |
| ing_ts | input | TS_W | Local arrival time in ns |
| egr_valid | input | 1 | Departure timestamp strobe |
| egr_type | input | 4 | Message type of the departing frame |
| egr_seq | input | SEQ_W | Sequence number of the departing frame |
| egr_ts | input | TS_W | Local departure time in ns |
| egr_corr_in | input | CORR_W | Correction field read from the departing frame |
| out_valid | output | 1 | Corrected value is available (one cycle) |
| out_corr | output | CORR_W | Correction value to write into the frame |
| out_miss | output | 1 | Event departure had no stored arrival |
| out_adjusted | output | 1 | Residence time was added |

## Verification
The hardest situations to reach are those where table state interacts with timing. One is an arrival and a departure with the same key in the same cycle. The other is overwriting a slot that still holds an unconsumed entry. The bench drives both strobes together on a single edge. It also sends one more arrival than the table can hold and then shows which key was lost. A sweep fills the table in groups and drains each group in reverse order, so that every slot and both message kinds are matched against arithmetically computed corrections.

// File: rtl/tc_pkg.sv
package tc_pkg;
  localparam logic [3:0] MSG_SYNC = 4'h0;
  localparam logic [3:0] MSG_DREQ = 4'h1;

  function automatic logic is_timed(input logic [3:0] t);
    return (t == MSG_SYNC) || (t == MSG_DREQ);
  endfunction

  function automatic logic kind_of(input logic [3:0] t);
    return t == MSG_DREQ;
  endfunction
endpackage

// File: rtl/tc_ts_table.sv
module tc_ts_table #(
  parameter int DEPTH = 4,
  parameter int TS_W  = 32,
  parameter int SEQ_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic             wr_kind,
  input  logic [SEQ_W-1:0] wr_seq,
  input  logic [TS_W-1:0]  wr_ts,
  input  logic             lk_en,
  input  logic             lk_kind,
  input  logic [SEQ_W-1:0] lk_seq,
  output logic             rd_hit,
  output logic [TS_W-1:0]  rd_ts
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [DEPTH-1:0] slot_vld;
  logic [DEPTH-1:0] slot_kind;
  logic [SEQ_W-1:0] slot_seq [DEPTH];
  logic [TS_W-1:0]  ts_mem   [DEPTH];
  logic [PTR_W-1:0] wptr;
  logic [DEPTH-1:0] match;
  logic [PTR_W-1:0] hit_idx;
  logic             any_hit;

  // Key compare per slot
  for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
    assign match[g] = slot_vld[g] && (slot_kind[g] == lk_kind) && (slot_seq[g] == lk_seq);
  end

  // Lowest matching slot wins
  always_comb begin
    hit_idx = '0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (match[i]) hit_idx = PTR_W'(i);
    end
  end
  assign any_hit = lk_en && (match != '0);

  // Key registers: consume on hit, a write in the same cycle wins
  always_ff @(posedge clk) begin
    if (rst) begin
      slot_vld <= '0;
      wptr     <= '0;
      rd_hit   <= 1'b0;
    end else begin
      rd_hit <= any_hit;
      if (any_hit) slot_vld[hit_idx] <= 1'b0;
      if (wr_en) begin
        slot_vld[wptr]  <= 1'b1;
        slot_kind[wptr] <= wr_kind;
        slot_seq[wptr]  <= wr_seq;
        wptr <= (wptr == PTR_W'(DEPTH - 1)) ? '0 : wptr + 1'b1;
      end
    end
  end

  // Timestamp storage: plain RAM with registered read-first port
  always_ff @(posedge clk) begin
    if (wr_en) ts_mem[wptr] <= wr_ts;
    rd_ts <= ts_mem[hit_idx];
  end
endmodule

// File: rtl/tc_corr_math.sv
module tc_corr_math #(
  parameter int TS_W   = 32,
  parameter int CORR_W = 64,
  parameter int FRAC   = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic              in_timed,
  input  logic              in_hit,
  input  logic [TS_W-1:0]   in_egr_ts,
  input  logic [TS_W-1:0]   in_ing_ts,
  input  logic [CORR_W-1:0] in_corr,
  output logic              out_valid,
  output logic [CORR_W-1:0] out_corr,
  output logic              out_miss,
  output logic              out_adjusted
);
  logic [TS_W-1:0]   resid;
  logic [CORR_W-1:0] scaled;

  assign resid  = in_egr_ts - in_ing_ts;
  assign scaled = CORR_W'(resid) << FRAC;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid    <= 1'b0;
      out_miss     <= 1'b0;
      out_adjusted <= 1'b0;
      out_corr     <= '0;
    end else begin
      out_valid    <= in_valid;
      out_miss     <= in_valid && in_timed && !in_hit;
      out_adjusted <= in_valid && in_timed && in_hit;
      out_corr     <= (in_valid && in_timed && in_hit) ? in_corr + scaled : in_corr;
    end
  end
endmodule

// File: rtl/tc_corr_updater.sv
module tc_corr_updater #(
  parameter int DEPTH  = 4,
  parameter int TS_W   = 32,
  parameter int SEQ_W  = 16,
  parameter int CORR_W = 64,
  parameter int FRAC   = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ing_valid,
  input  logic [3:0]        ing_type,
  input  logic [SEQ_W-1:0]  ing_seq,
  input  logic [TS_W-1:0]   ing_ts,
  input  logic              egr_valid,
  input  logic [3:0]        egr_type,
  input  logic [SEQ_W-1:0]  egr_seq,
  input  logic [TS_W-1:0]   egr_ts,
  input  logic [CORR_W-1:0] egr_corr_in,
  output logic              out_valid,
  output logic [CORR_W-1:0] out_corr,
  output logic              out_miss,
  output logic              out_adjusted
);
  import tc_pkg::*;

  logic              wr_en, lk_en, rd_hit;
  logic [TS_W-1:0]   rd_ts;
  logic              s1_valid, s1_timed;
  logic [TS_W-1:0]   s1_ts;
  logic [CORR_W-1:0] s1_corr;

  assign wr_en = ing_valid && is_timed(ing_type);
  assign lk_en = egr_valid && is_timed(egr_type);

  tc_ts_table #(.DEPTH(DEPTH), .TS_W(TS_W), .SEQ_W(SEQ_W)) u_table (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .wr_kind (kind_of(ing_type)),
    .wr_seq  (ing_seq),
    .wr_ts   (ing_ts),
    .lk_en   (lk_en),
    .lk_kind (kind_of(egr_type)),
    .lk_seq  (egr_seq),
    .rd_hit  (rd_hit),
    .rd_ts   (rd_ts)
  );

  // Stage 1: align the departure data with the table read
  always_ff @(posedge clk) begin
    if (rst) begin
      s1_valid <= 1'b0;
      s1_timed <= 1'b0;
      s1_ts    <= '0;
      s1_corr  <= '0;
    end else begin
      s1_valid <= egr_valid;
      s1_timed <= lk_en;
      s1_ts    <= egr_ts;
      s1_corr  <= egr_corr_in;
    end
  end

  tc_corr_math #(.TS_W(TS_W), .CORR_W(CORR_W), .FRAC(FRAC)) u_math (
    .clk          (clk),
    .rst          (rst),
    .in_valid     (s1_valid),
    .in_timed     (s1_timed),
    .in_hit       (rd_hit),
    .in_egr_ts    (s1_ts),
    .in_ing_ts    (rd_ts),
    .in_corr      (s1_corr),
    .out_valid    (out_valid),
    .out_corr     (out_corr),
    .out_miss     (out_miss),
    .out_adjusted (out_adjusted)
  );
endmodule

// File: rtl/tc_corr_updater_chk.sv
module tc_corr_updater_chk #(
  parameter int CORR_W = 64
) (
  input logic              clk,
  input logic              rst,
  input logic              egr_valid,
  input logic [3:0]        egr_type,
  input logic [CORR_W-1:0] egr_corr_in,
  input logic              out_valid,
  input logic [CORR_W-1:0] out_corr,
  input logic              out_miss,
  input logic              out_adjusted
);
  logic              p1_v, p2_v, p1_ev, p2_ev;
  logic [CORR_W-1:0] p1_c, p2_c;

  always_ff @(posedge clk) begin
    if (rst) begin
      p1_v <= 1'b0; p2_v <= 1'b0; p1_ev <= 1'b0; p2_ev <= 1'b0;
      p1_c <= '0;   p2_c <= '0;
    end else begin
      p1_v  <= egr_valid;
      p2_v  <= p1_v;
      p1_ev <= egr_valid && (egr_type == 4'h0 || egr_type == 4'h1);
      p2_ev <= p1_ev;
      p1_c  <= egr_corr_in;
      p2_c  <= p1_c;
    end
  end

  assert_reset_idle_R1: assert property (@(posedge clk) rst |=> (!out_valid && !out_miss && !out_adjusted));

  assert_latency_R10: assert property (@(posedge clk) disable iff (rst) out_valid == p2_v);

  assert_flags_excl_R10: assert property (@(posedge clk) disable iff (rst)
    (out_miss || out_adjusted) |-> (out_valid && !(out_miss && out_adjusted)));

  assert_event_flagged_R2: assert property (@(posedge clk) disable iff (rst)
    (out_valid && p2_ev) |-> (out_miss || out_adjusted));

  assert_nonevent_pass_R4: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !p2_ev) |-> (!out_miss && !out_adjusted && out_corr == p2_c));

  assert_miss_unchanged_R6: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_miss) |-> (out_corr == p2_c));
endmodule

bind tc_corr_updater tc_corr_updater_chk #(.CORR_W(CORR_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .egr_valid   (egr_valid),
  .egr_type    (egr_type),
  .egr_corr_in (egr_corr_in),
  .out_valid   (out_valid),
  .out_corr    (out_corr),
  .out_miss    (out_miss),
  .out_adjusted(out_adjusted)
);

// File: tb/tc_corr_updater_bench.sv
module tc_corr_updater_bench;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 4;
  localparam int TS_W = 32;
  localparam int SEQ_W = 16;
  localparam int CORR_W = 64;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              ing_valid = 1'b0;
  logic [3:0]        ing_type = '0;
  logic [SEQ_W-1:0]  ing_seq = '0;
  logic [TS_W-1:0]   ing_ts = '0;
  logic              egr_valid = 1'b0;
  logic [3:0]        egr_type = '0;
  logic [SEQ_W-1:0]  egr_seq = '0;
  logic [TS_W-1:0]   egr_ts = '0;
  logic [CORR_W-1:0] egr_corr_in = '0;
  logic              out_valid, out_miss, out_adjusted;
  logic [CORR_W-1:0] out_corr;

  int errors = 0;
  int checks = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  tc_corr_updater #(.DEPTH(DEPTH), .TS_W(TS_W), .SEQ_W(SEQ_W), .CORR_W(CORR_W)) u_tc_corr_updater (
    .clk(clk), .rst(rst),
    .ing_valid(ing_valid), .ing_type(ing_type), .ing_seq(ing_seq), .ing_ts(ing_ts),
    .egr_valid(egr_valid), .egr_type(egr_type), .egr_seq(egr_seq), .egr_ts(egr_ts),
    .egr_corr_in(egr_corr_in),
    .out_valid(out_valid), .out_corr(out_corr), .out_miss(out_miss), .out_adjusted(out_adjusted)
  );

  task automatic chk(input string req, input logic [CORR_W-1:0] act, input logic [CORR_W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [CORR_W-1:0] upd(input logic [CORR_W-1:0] c,
                                            input logic [TS_W-1:0] ti, input logic [TS_W-1:0] te);
    logic [TS_W-1:0] d;
    d = te - ti;
    return c + ({{(CORR_W-TS_W){1'b0}}, d} << 16);
  endfunction

  task automatic arrive(input logic [3:0] t, input logic [SEQ_W-1:0] s, input logic [TS_W-1:0] ts);
    @(negedge clk);
    ing_valid = 1'b1; ing_type = t; ing_seq = s; ing_ts = ts;
    @(negedge clk);
    ing_valid = 1'b0;
  endtask

  // Strobe a departure and check its result two edges later, then the pulse end
  task automatic depart(input string req, input logic [3:0] t, input logic [SEQ_W-1:0] s,
                        input logic [TS_W-1:0] ts, input logic [CORR_W-1:0] c,
                        input logic [CORR_W-1:0] exp_c, input logic exp_miss, input logic exp_adj);
    @(negedge clk);
    egr_valid = 1'b1; egr_type = t; egr_seq = s; egr_ts = ts; egr_corr_in = c;
    @(negedge clk);
    egr_valid = 1'b0;
    @(negedge clk);
    chk({req, " valid"}, 64'(out_valid), 64'd1);
    chk({req, " corr"}, out_corr, exp_c);
    chk({req, " miss"}, 64'(out_miss), 64'(exp_miss));
    chk({req, " adjusted"}, 64'(out_adjusted), 64'(exp_adj));
    @(negedge clk);
    chk("R10 single pulse", 64'(out_valid), 64'd0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [TS_W-1:0]   its [DEPTH];
    logic [TS_W-1:0]   ets [DEPTH];
    logic [CORR_W-1:0] cv  [DEPTH];
    repeat (3) @(negedge clk);
    chk("R1 valid in reset", 64'(out_valid), 64'd0);
    chk("R1 miss in reset", 64'(out_miss), 64'd0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 valid after reset", 64'(out_valid), 64'd0);
    chk("R1 adjusted after reset", 64'(out_adjusted), 64'd0);
    depart("R1 empty table", 4'h0, 16'd5, 32'd100, 64'h1234, 64'h1234, 1'b1, 1'b0);

    // Sweep: fill in groups of DEPTH, drain in reverse order (R2 Sync, R3 Delay_Req)
    for (int grp = 0; grp < 8; grp++) begin
      for (int k = 0; k < DEPTH; k++) begin
        int i;
        i = grp * DEPTH + k;
        its[k] = 32'(i) * 32'h9E3779B9;
        ets[k] = its[k] + ((i == 31) ? 32'hFFFF_FFFF : 32'(i * i * 131 + i));
        cv[k]  = (64'(i) * 64'hF00D_0000_0001_2345) ^ 64'h8000_0000_0000_0000;
        arrive(4'(i % 2), 16'(i * 97 + 3), its[k]);
      end
      for (int k = DEPTH - 1; k >= 0; k--) begin
        int i;
        i = grp * DEPTH + k;
        depart((i % 2 == 0) ? "R2 sync sweep" : "R3 dreq sweep", 4'(i % 2), 16'(i * 97 + 3),
               ets[k], cv[k], upd(cv[k], its[k], ets[k]), 1'b0, 1'b1);
      end
    end

    // R5: kind is part of the key
    arrive(4'h0, 16'd9, 32'd100);
    arrive(4'h1, 16'd9, 32'd500);
    depart("R5 dreq same seq", 4'h1, 16'd9, 32'd600, 64'd0, 64'd100 << 16, 1'b0, 1'b1);
    depart("R5 sync same seq", 4'h0, 16'd9, 32'd150, 64'd7, 64'd7 + (64'd50 << 16), 1'b0, 1'b1);
    // R7: consumed
    depart("R7 consumed", 4'h0, 16'd9, 32'd160, 64'd7, 64'd7, 1'b1, 1'b0);
    // R6: unknown key
    depart("R6 miss", 4'h1, 16'd777, 32'd10, 64'hFFFF_FFFF_FFFF_0000, 64'hFFFF_FFFF_FFFF_0000, 1'b1, 1'b0);

    // R4: non-event frames do not displace entries and pass through
    for (int k = 0; k < DEPTH; k++) arrive(4'h0, 16'(20 + k), 32'(1000 * k));
    arrive(4'h8, 16'd20, 32'd0);
    arrive(4'hB, 16'd21, 32'd0);
    depart("R4 nonevent pass", 4'h8, 16'd20, 32'd5, 64'hABCD, 64'hABCD, 1'b0, 1'b0);
    for (int k = 0; k < DEPTH; k++)
      depart("R4 entries kept", 4'h0, 16'(20 + k), 32'(1000 * k + 3), 64'd1,
             64'd1 + (64'd3 << 16), 1'b0, 1'b1);

    // R8: overflow overwrites oldest
    for (int k = 0; k <= DEPTH; k++) arrive(4'h1, 16'(30 + k), 32'(50 * k));
    depart("R8 oldest lost", 4'h1, 16'd30, 32'd999, 64'd2, 64'd2, 1'b1, 1'b0);
    for (int k = 1; k <= DEPTH; k++)
      depart("R8 newer kept", 4'h1, 16'(30 + k), 32'(50 * k + 9), 64'd2,
             64'd2 + (64'd9 << 16), 1'b0, 1'b1);

    // R9: timestamp wrap
    arrive(4'h0, 16'd60, 32'hFFFF_FF00);
    depart("R9 wrap", 4'h0, 16'd60, 32'h0000_0100, 64'd0, 64'h200 << 16, 1'b0, 1'b1);

    // R11: same-cycle arrival and departure of one key
    @(negedge clk);
    ing_valid = 1'b1; ing_type = 4'h0; ing_seq = 16'd40; ing_ts = 32'd300;
    egr_valid = 1'b1; egr_type = 4'h0; egr_seq = 16'd40; egr_ts = 32'd310; egr_corr_in = 64'd4;
    @(negedge clk);
    ing_valid = 1'b0; egr_valid = 1'b0;
    @(negedge clk);
    chk("R11 same cycle miss", 64'(out_miss), 64'd1);
    chk("R11 same cycle corr", out_corr, 64'd4);
    depart("R11 stored later", 4'h0, 16'd40, 32'd320, 64'd4, 64'd4 + (64'd20 << 16), 1'b0, 1'b1);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule